// File: doc/BRIEF.md
# Pipelined Synchronous Word SRAM

This block is a synthesizable model of a single-port synchronous SRAM. Each word is 32 bits wide, and each of its four byte lanes can be written on its own. Every control, address and write-data input is captured on the rising clock edge. A selected cycle is a write if the full-word write strobe or any lane strobe is high, and a read otherwise. Read data goes through an output register, so it appears one clock after the access is captured. The shared data bus is modelled as two ports, `rdata` and `rdata_en`. `rdata_en` high means the block drives the bus. `rdata_en` low stands for high impedance.

Three synchronous enables must all be active for the device to count as selected. The output enable `oe` gates the bus without reference to the clock. A small output state machine records what the last captured access was. Its states are:

- `S_OFF`: deselected, or just out of reset.
- `S_WRITE`: the last access was a write.
- `S_MASK`: the first read after a deselected cycle.
- `S_READ`: a normal read.

Its transitions, taken at every edge, are:

- Any state goes to `S_OFF` on a deselected access.
- Any state goes to `S_WRITE` on a selected write.
- Any state goes to `S_MASK` on a selected read whose previous cycle was deselected.
- Any state goes to `S_READ` on a selected read whose previous cycle was selected.

Only `S_READ` lets `oe` reach the bus. The memory depth is set by the `ADDR_W` parameter (`2**ADDR_W` words). A full 64K-word array uses `ADDR_W = 16`.

Top module: `pipe_sram`

## Requirements
- R1: The device is selected only when `ce_a`=1, `ce_b`=1 and `ce_c_n`=0 at the clock edge. Any other combination is a deselected cycle: nothing is written and the bus stays undriven.
- R2: A read captured at edge k loads the word into the output register at edge k+1. After edge k+1, `rdata` holds that word and `rdata_en` is 1, provided `oe`=1 and the read is not masked.
- R3: In a write with `gwe`=0, `byte_we[i]`=1 updates bits [8i+7:8i] from `wdata`. Lanes whose `byte_we` bit is 0 keep their old contents.
- R4: With `gwe`=1, all four lanes are written, whatever `byte_we` holds.
- R5: A selected cycle is a write when `gwe`=1 or any `byte_we` bit is 1. The cycle after a write is captured leaves `rdata_en`=0.
- R6: `oe` acts without a clock. While the state is `S_READ`, `rdata_en` follows `oe` at once.
- R7: A read captured in the cycle right after a deselected cycle (or right after reset) leaves `rdata_en`=0 for its data cycle, even with `oe`=1.
- R8: While the last captured access is deselected, `rdata_en`=0 regardless of `oe`, and a write strobe has no effect on the array.
- R9: A read captured at the edge right after a write to the same address returns the newly written word.
- R10: While reset is held and after it is released, `rdata_en`=0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| byte_we | input | 4 | Per-lane write strobes, bit i covers bits [8i+7:8i] |
| gwe | input | 1 | Full-word write strobe |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 32 | Output register contents |
| rdata_en | output | 1 | Bus drive flag (0 means high impedance) |

## Verification
The bench reads back a word that mixes lane strobes. A design that ignored the lane mask, or shifted it by one lane, would return the wrong bytes. The bench also issues a read straight after a deselected cycle and expects the bus to stay undriven. A model without the mask would drive stale or early data, and one that masked too long would hide the next read. Each enable is made inactive on its own during a full-word write. A decode missing one term would corrupt the word read afterwards. Finally, the bench toggles `oe` in the middle of a cycle, which catches an enable that was wrongly registered, and reads back straight after a write, which catches a stale array read.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_WRITE = 2'd1,
        S_MASK  = 2'd2,
        S_READ  = 2'd3
    } out_state_t;
endpackage

// File: rtl/sram_in_stage.sv
`timescale 1ns/1ps
module sram_in_stage
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  byte_we,
    input  logic              gwe,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              ce_c_n,
    output logic              sel_q,
    output logic              wr_q,
    output logic [LANES-1:0]  mask_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata_q
);
    logic             sel_d;
    logic             wr_d;
    logic [LANES-1:0] mask_d;

    always_comb begin
        sel_d  = ce_a & ce_b & ~ce_c_n;
        wr_d   = sel_d & (gwe | (|byte_we));
        mask_d = gwe ? {LANES{1'b1}} : byte_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
            mask_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            sel_q   <= sel_d;
            wr_q    <= wr_d;
            mask_q  <= mask_d;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    AST_SEL_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_a || !ce_b || ce_c_n) |=> !sel_q);  // R1

    AST_GWE_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (gwe && ce_a && ce_b && !ce_c_n) |=> (wr_q && mask_q == {LANES{1'b1}}));  // R4
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_we[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/sram_out_ctrl.sv
`timescale 1ns/1ps
module sram_out_ctrl
    import sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_q,
    input  logic              wr_q,
    input  logic [WORD_W-1:0] arr_rdata,
    input  logic              oe,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    out_state_t        state;
    out_state_t        state_nx;
    logic              prev_sel;
    logic [WORD_W-1:0] dout_q;

    always_comb begin
        unique case ({sel_q, wr_q, prev_sel})
            3'b000, 3'b001, 3'b010, 3'b011: state_nx = S_OFF;
            3'b110, 3'b111:                 state_nx = S_WRITE;
            3'b100:                         state_nx = S_MASK;
            3'b101:                         state_nx = S_READ;
            default:                        state_nx = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_OFF;
            prev_sel <= 1'b0;
        end else begin
            state    <= state_nx;
            prev_sel <= sel_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (sel_q && !wr_q) begin
            dout_q <= arr_rdata;
        end
    end

    always_comb begin
        dout = dout_q;
        unique case (state)
            S_OFF:   dout_en = 1'b0;
            S_WRITE: dout_en = 1'b0;
            S_MASK:  dout_en = 1'b0;
            S_READ:  dout_en = oe;
            default: dout_en = 1'b0;
        endcase
    end

    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |=> !dout_en);  // R8

    AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !wr_q && !prev_sel) |=> !dout_en);  // R7

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && wr_q) |=> !dout_en);  // R5

    AST_READ_DATA_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !wr_q) |=> (dout == $past(arr_rdata)));  // R2
endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        byte_we,
    input  logic              gwe,
    input  logic              ce_a,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              oe,
    output logic [31:0]       rdata,
    output logic              rdata_en
);
    logic              sel_q;
    logic              wr_q;
    logic [LANES-1:0]  mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] arr_rdata;

    sram_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .byte_we (byte_we),
        .gwe     (gwe),
        .ce_a    (ce_a),
        .ce_b    (ce_b),
        .ce_c_n  (ce_c_n),
        .sel_q   (sel_q),
        .wr_q    (wr_q),
        .mask_q  (mask_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    sram_lane_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .wr_en   (sel_q & wr_q),
        .lane_we (mask_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .rdata   (arr_rdata)
    );

    sram_out_ctrl u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_q     (sel_q),
        .wr_q      (wr_q),
        .arr_rdata (arr_rdata),
        .oe        (oe),
        .dout      (rdata),
        .dout_en   (rdata_en)
    );
endmodule

// File: tb/pipe_sram_tb.sv
`timescale 1ns/1ps
module pipe_sram_tb;
    localparam int AW = 10;
    localparam logic [2:0] SEL  = 3'b110;
    localparam logic [2:0] NONE = 3'b001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    byte_we = '0;
    logic          gwe = 1'b0;
    logic          ce_a = 1'b0;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic          oe = 1'b1;
    logic [31:0]   rdata;
    logic          rdata_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pipe_sram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .byte_we(byte_we), .gwe(gwe), .ce_a(ce_a), .ce_b(ce_b),
        .ce_c_n(ce_c_n), .oe(oe), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: inputs set at the falling edge, returns 1 ns after the rising edge
    task automatic cyc(input logic [2:0] ce, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic [3:0] bw, input logic g);
        @(negedge clk);
        {ce_a, ce_b, ce_c_n} = ce;
        addr = a; wdata = d; byte_we = bw; gwe = g;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R10 en during reset", {31'b0, rdata_en}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R10 en after reset", {31'b0, rdata_en}, 32'd0);
    endtask

    task automatic t_full_write;
        cyc(NONE, '0, '0, '0, 1'b0);
        cyc(SEL, 10'd5, 32'h11223344, 4'b0000, 1'b1);
        cyc(SEL, 10'd5, '0, '0, 1'b0);
        chk("R5 no drive after write", {31'b0, rdata_en}, 32'd0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R4 en", {31'b0, rdata_en}, 32'd1);
        chk("R4 full word", rdata, 32'h11223344);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R8 idle no drive", {31'b0, rdata_en}, 32'd0);
    endtask

    task automatic t_lanes;
        cyc(SEL, 10'd7, 32'hAABBCCDD, 4'b0000, 1'b1);
        cyc(SEL, 10'd7, 32'h11223344, 4'b0101, 1'b0);
        cyc(SEL, 10'd7, '0, '0, 1'b0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R3 lane mix", rdata, 32'hAA22CC44);
        cyc(SEL, 10'd7, 32'h55667788, 4'b1000, 1'b0);
        cyc(SEL, 10'd7, '0, '0, 1'b0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R3 top lane", rdata, 32'h5522CC44);
    endtask

    task automatic t_mask_oe;
        cyc(NONE, '0, '0, '0, 1'b0);
        cyc(SEL, 10'd7, '0, '0, 1'b0);
        cyc(SEL, 10'd5, '0, '0, 1'b0);
        chk("R7 first read masked", {31'b0, rdata_en}, 32'd0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R2 second read en", {31'b0, rdata_en}, 32'd1);
        chk("R2 second read data", rdata, 32'h11223344);
        oe = 1'b0; #0.5;
        chk("R6 oe low", {31'b0, rdata_en}, 32'd0);
        oe = 1'b1; #0.5;
        chk("R6 oe high", {31'b0, rdata_en}, 32'd1);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R8 after read", {31'b0, rdata_en}, 32'd0);
    endtask

    task automatic t_partial_select;
        logic [2:0] pats [3] = '{3'b010, 3'b100, 3'b111};
        cyc(SEL, 10'd9, 32'h00000000, 4'b0000, 1'b1);
        foreach (pats[i]) begin
            cyc(pats[i], 10'd9, 32'hDEADBEEF, 4'b1111, 1'b1);
            cyc(pats[i], 10'd9, '0, '0, 1'b0);
            cyc(NONE, '0, '0, '0, 1'b0);
            chk("R1 partial select no drive", {31'b0, rdata_en}, 32'd0);
        end
        cyc(SEL, 10'd9, '0, '0, 1'b0);
        cyc(SEL, 10'd9, '0, '0, 1'b0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R1 word untouched", rdata, 32'h00000000);
    endtask

    task automatic t_desel_write;
        cyc(NONE, 10'd5, 32'hFFFFFFFF, 4'b1111, 1'b1);
        chk("R8 deselected en", {31'b0, rdata_en}, 32'd0);
        cyc(SEL, 10'd5, '0, '0, 1'b0);
        cyc(SEL, 10'd5, '0, '0, 1'b0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R8 array untouched", rdata, 32'h11223344);
    endtask

    task automatic t_wr_then_rd;
        cyc(SEL, 10'd12, 32'hCAFEF00D, 4'b0000, 1'b1);
        cyc(SEL, 10'd12, '0, '0, 1'b0);
        cyc(NONE, '0, '0, '0, 1'b0);
        chk("R9 read after write en", {31'b0, rdata_en}, 32'd1);
        chk("R9 read after write data", rdata, 32'hCAFEF00D);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_full_write();
        t_lanes();
        t_mask_oe();
        t_partial_select();
        t_desel_write();
        t_wr_then_rd();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule